// File: doc/BRIEF.md
# Banked Scratchpad with Bit Addressing

This block is the 128-byte internal working memory of an 8-bit core. One storage array serves four views of the same bytes: plain byte access by a 7-bit direct address, register access by a 3-bit register number inside the active bank, single-bit access by a 7-bit bit address, and an upward-growing stack driven by an internal stack pointer.

Each cycle the core issues one command on `cmd`. Reads return their result in the cycle after the command. All writes also take effect in that cycle. A bit set or clear is a read-modify-write of the addressed byte, and it completes in the same single cycle. The bank and the stack pointer are registers inside the block, and the core changes them with dedicated commands.

Top module: `banked_scratchpad`

## Requirements
- R1: After synchronous reset, `sp` is 07H, `bank` is 0, `sp_ovf` is 0, and `rdata` and `rbit` are 0.
- R2: Command 2 writes `wdata` to the byte at `addr`. Command 1 reads the byte at `addr` onto `rdata` in the next cycle.
- R3: Commands 3 (read) and 4 (write) access register `regnum` of the active bank at byte address bank×8+regnum. The same byte can also be reached by its direct address, whichever bank is active.
- R4: Command 11 loads the bank from `wdata[1:0]`. The new value appears on `bank` in the next cycle and applies to every later register command.
- R5: Command 5 reads the bit at bit address `addr` onto `rbit` in the next cycle. Bit address b selects bit b[2:0] of byte 20H + b[6:3].
- R6: Command 6 sets and command 7 clears that bit. The other seven bits of the byte are left unchanged.
- R7: Command 8 (push) first increments `sp` and then writes `wdata` at the new `sp`.
- R8: Command 9 (pop) places the byte at the current `sp` on `rdata` and then decrements `sp`.
- R9: Command 10 loads `sp` from `wdata[6:0]`, with bit 7 of `sp` always 0, and clears `sp_ovf`.
- R10: `sp` wraps modulo 128 on push and pop. `sp_ovf` is set by a push that leaves `sp` at 7FH and stays set until reset or command 10.
- R11: Commands other than 1, 3 and 9 leave `rdata` unchanged. Commands other than 5 leave `rbit` unchanged. Command 0 and the codes 12 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 4 | Command code, one per cycle |
| addr | input | 7 | Direct byte address, or bit address for bit commands |
| regnum | input | 3 | Register number within the active bank |
| wdata | input | 8 | Write, push, stack pointer or bank load data |
| rdata | output | 8 | Byte result of the last byte, register or pop read |
| rbit | output | 1 | Result of the last bit read |
| sp | output | 8 | Stack pointer |
| sp_ovf | output | 1 | Sticky stack overflow flag |
| bank | output | 2 | Active register bank |

## Verification
Every result is due exactly one clock edge after its command is presented: `rdata`, `rbit`, `sp`, `sp_ovf` and `bank` are registered, and memory writes are visible to a read issued in the next cycle. The bench presents each command at a falling edge and updates its behavioural model at the following rising edge. It compares all five outputs 1 ns after that rising edge, so each check sees the state after exactly one command. Stack wrap, the overflow flag at 7FH, bank aliasing and single-bit updates are driven as directed cases, and a long random command stream follows them.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
    localparam int AW        = 7;
    localparam int DW        = 8;
    localparam int DEPTH     = 1 << AW;
    localparam int BANK_W    = 2;
    localparam int REG_W     = 3;
    localparam int BSEL_W    = $clog2(DW);
    localparam logic [AW-1:0] BIT_BASE = 7'h20;
    localparam logic [AW-1:0] SP_RESET = 7'h07;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_RD_BYTE = 4'd1,
        OP_WR_BYTE = 4'd2,
        OP_RD_REG  = 4'd3,
        OP_WR_REG  = 4'd4,
        OP_RD_BIT  = 4'd5,
        OP_SET_BIT = 4'd6,
        OP_CLR_BIT = 4'd7,
        OP_PUSH    = 4'd8,
        OP_POP     = 4'd9,
        OP_LD_SP   = 4'd10,
        OP_LD_BANK = 4'd11
    } op_e;

    typedef struct packed {
        logic [AW-1:0]     addr;
        logic [BSEL_W-1:0] bsel;
        logic              wr_byte;
        logic              wr_bit;
        logic              bit_val;
    } access_t;

    function automatic logic [AW-1:0] reg_to_addr(input logic [BANK_W-1:0] b,
                                                  input logic [REG_W-1:0] r);
        return AW'({b, r});
    endfunction

    function automatic logic [AW-1:0] bit_to_addr(input logic [AW-1:0] b);
        return BIT_BASE + AW'(b[AW-1:BSEL_W]);
    endfunction
endpackage

// File: rtl/sp_unit.sv
module sp_unit
    import scratch_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] sp_q,
    output logic [AW-1:0] sp_inc,
    output logic          ovf_q
);
    localparam logic [AW-1:0] TOP = '1;

    assign sp_inc = sp_q + AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= SP_RESET;
            ovf_q <= 1'b0;
        end else if (load) begin
            sp_q  <= load_val;
            ovf_q <= 1'b0;
        end else if (push) begin
            sp_q <= sp_inc;
            if (sp_inc == TOP) ovf_q <= 1'b1;
        end else if (pop) begin
            sp_q <= sp_q - AW'(1);
        end
    end

    p_sp_reset_r1: assert property (@(posedge clk) $past(rst) |-> (sp_q == SP_RESET && !ovf_q));
    p_push_inc_r7: assert property (@(posedge clk) disable iff (rst)
        push && !load |=> sp_q == AW'($past(sp_q) + AW'(1)));
    p_pop_dec_r8: assert property (@(posedge clk) disable iff (rst)
        pop && !load && !push |=> sp_q == AW'($past(sp_q) - AW'(1)));
    p_load_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> (sp_q == $past(load_val) && !ovf_q));
    p_ovf_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> ($past(push) && sp_q == TOP));
endmodule

// File: rtl/addr_resolve.sv
module addr_resolve
    import scratch_pkg::*;
(
    input  op_e               op,
    input  logic [AW-1:0]     addr,
    input  logic [REG_W-1:0]  regnum,
    input  logic [BANK_W-1:0] bank,
    input  logic [AW-1:0]     sp,
    input  logic [AW-1:0]     sp_inc,
    output access_t           acc
);
    always_comb begin
        acc         = '0;
        acc.addr    = addr;
        acc.bsel    = addr[BSEL_W-1:0];
        case (op)
            OP_RD_REG, OP_WR_REG: begin
                acc.addr    = reg_to_addr(bank, regnum);
                acc.wr_byte = (op == OP_WR_REG);
            end
            OP_WR_BYTE: acc.wr_byte = 1'b1;
            OP_RD_BIT, OP_SET_BIT, OP_CLR_BIT: begin
                acc.addr    = bit_to_addr(addr);
                acc.wr_bit  = (op != OP_RD_BIT);
                acc.bit_val = (op == OP_SET_BIT);
            end
            OP_PUSH: begin
                acc.addr    = sp_inc;
                acc.wr_byte = 1'b1;
            end
            OP_POP:  acc.addr = sp;
            default: ;
        endcase
    end
endmodule

// File: rtl/ram_core.sv
module ram_core
    import scratch_pkg::*;
(
    input  logic          clk,
    input  logic [AW-1:0] a,
    input  logic          we,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] mem [DEPTH];

    assign rd = mem[a];

    always_ff @(posedge clk) begin
        if (we) mem[a] <= wd;
    end
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
    import scratch_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    cmd,
    input  logic [6:0]    addr,
    input  logic [2:0]    regnum,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          rbit,
    output logic [7:0]    sp,
    output logic          sp_ovf,
    output logic [1:0]    bank
);
    op_e           op;
    access_t       acc;
    logic [AW-1:0] sp_q, sp_inc;
    logic [DW-1:0] rd_byte, wr_byte;
    logic          we;
    logic          rd_op;

    assign op = op_e'(cmd);

    sp_unit u_sp (
        .clk(clk), .rst(rst),
        .push(op == OP_PUSH), .pop(op == OP_POP), .load(op == OP_LD_SP),
        .load_val(wdata[AW-1:0]),
        .sp_q(sp_q), .sp_inc(sp_inc), .ovf_q(sp_ovf)
    );

    addr_resolve u_res (
        .op(op), .addr(addr), .regnum(regnum), .bank(bank),
        .sp(sp_q), .sp_inc(sp_inc), .acc(acc)
    );

    always_comb begin
        wr_byte = wdata;
        if (acc.wr_bit) begin
            wr_byte           = rd_byte;
            wr_byte[acc.bsel] = acc.bit_val;
        end
    end

    assign we = acc.wr_byte | acc.wr_bit;

    ram_core u_ram (
        .clk(clk), .a(acc.addr), .we(we), .wd(wr_byte), .rd(rd_byte)
    );

    assign rd_op = (op == OP_RD_BYTE) || (op == OP_RD_REG) || (op == OP_POP);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            rbit  <= 1'b0;
            bank  <= '0;
        end else begin
            if (rd_op)             rdata <= rd_byte;
            if (op == OP_RD_BIT)   rbit  <= rd_byte[acc.bsel];
            if (op == OP_LD_BANK)  bank  <= wdata[BANK_W-1:0];
        end
    end

    assign sp = {1'b0, sp_q};

    p_bit_single_r6: assert property (@(posedge clk) disable iff (rst)
        acc.wr_bit |-> $countones(wr_byte ^ rd_byte) <= 1);
    p_bit_region_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_BIT || acc.wr_bit) |-> (acc.addr >= BIT_BASE && acc.addr < BIT_BASE + AW'(16)));
    p_bank_load_r4: assert property (@(posedge clk) disable iff (rst)
        op == OP_LD_BANK |=> bank == $past(wdata[BANK_W-1:0]));
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_op |=> $stable(rdata));
    p_reg_window_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_REG || op == OP_WR_REG) |-> acc.addr < AW'(32));
endmodule

// File: tb/tb_banked_scratchpad.sv
module tb_banked_scratchpad;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cmd = 4'd0;
    logic [6:0] addr = '0;
    logic [2:0] regnum = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, sp;
    logic       rbit, sp_ovf;
    logic [1:0] bank;

    int errors = 0;
    int checks = 0;

    logic [7:0] m_mem [128];
    int         m_sp, m_bank;
    logic [7:0] m_rdata;
    logic       m_rbit, m_ovf;

    always #5 clk = ~clk;

    banked_scratchpad dut (
        .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .regnum(regnum),
        .wdata(wdata), .rdata(rdata), .rbit(rbit), .sp(sp),
        .sp_ovf(sp_ovf), .bank(bank)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        check(req, "rdata", int'(rdata), int'(m_rdata));
        check(req, "rbit", int'(rbit), int'(m_rbit));
        check(req, "sp", int'(sp), m_sp);
        check(req, "sp_ovf", int'(sp_ovf), int'(m_ovf));
        check(req, "bank", int'(bank), m_bank);
    endtask

    task automatic model(input int c, input int a, input int r, input int d);
        int ba;
        ba = 32 + (a >> 3);
        case (c)
            1: m_rdata = m_mem[a];
            2: m_mem[a] = 8'(d);
            3: m_rdata = m_mem[m_bank * 8 + r];
            4: m_mem[m_bank * 8 + r] = 8'(d);
            5: m_rbit = m_mem[ba][a % 8];
            6: m_mem[ba][a % 8] = 1'b1;
            7: m_mem[ba][a % 8] = 1'b0;
            8: begin
                m_sp = (m_sp + 1) % 128;
                m_mem[m_sp] = 8'(d);
                if (m_sp == 127) m_ovf = 1'b1;
            end
            9: begin
                m_rdata = m_mem[m_sp];
                m_sp = (m_sp + 127) % 128;
            end
            10: begin
                m_sp = d % 128;
                m_ovf = 1'b0;
            end
            11: m_bank = d % 4;
            default: ;
        endcase
    endtask

    task automatic step(input string req, input int c, input int a, input int r, input int d);
        @(negedge clk);
        cmd = 4'(c); addr = 7'(a); regnum = 3'(r); wdata = 8'(d);
        @(posedge clk);
        model(c, a, r, d);
        #1;
        compare_all(req);
    endtask

    initial begin : watchdog
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_sp = 7; m_bank = 0; m_rdata = '0; m_rbit = 1'b0; m_ovf = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare_all("R1");

        // R2: fill every byte, read several back
        for (int i = 0; i < 128; i++) step("R2", 2, i, 0, (i * 37 + 5) & 8'hFF);
        step("R2", 1, 7'h00, 0, 0);
        step("R2", 1, 7'h7F, 0, 0);
        step("R2", 1, 7'h33, 0, 0);
        step("R11", 2, 7'h33, 0, 8'hA5);
        step("R11", 0, 0, 0, 0);
        step("R11", 12, 7'h33, 0, 8'h11);
        step("R2", 1, 7'h33, 0, 0);

        // R3/R4: banks and aliasing
        step("R3", 4, 0, 5, 8'h5B);
        step("R3", 1, 7'h05, 0, 0);
        step("R4", 11, 0, 0, 8'hFE);
        step("R3", 4, 0, 5, 8'hC3);
        step("R3", 1, 7'h15, 0, 0);
        step("R3", 3, 0, 5, 0);
        step("R4", 11, 0, 0, 8'h03);
        step("R3", 4, 0, 7, 8'h77);
        step("R3", 1, 7'h1F, 0, 0);
        step("R3", 2, 7'h18, 0, 8'h9D);
        step("R3", 3, 0, 0, 0);

        // R5/R6: bit access at region edges
        step("R6", 2, 7'h2F, 0, 8'h00);
        step("R6", 6, 7'h7F, 0, 0);
        step("R6", 1, 7'h2F, 0, 0);
        step("R5", 5, 7'h7F, 0, 0);
        step("R5", 5, 7'h7E, 0, 0);
        step("R6", 2, 7'h20, 0, 8'hFF);
        step("R6", 7, 7'h00, 0, 0);
        step("R6", 1, 7'h20, 0, 0);
        step("R5", 5, 7'h00, 0, 0);
        step("R5", 5, 7'h01, 0, 0);
        step("R6", 7, 7'h2B, 0, 0);
        step("R6", 1, 7'h25, 0, 0);

        // R7/R8/R9/R10: stack
        step("R7", 8, 0, 0, 8'h42);
        step("R7", 1, 7'h08, 0, 0);
        step("R8", 9, 0, 0, 0);
        step("R9", 10, 0, 0, 8'hB2);
        step("R7", 8, 0, 0, 8'h13);
        step("R7", 8, 0, 0, 8'h14);
        step("R8", 9, 0, 0, 0);
        step("R8", 9, 0, 0, 0);
        step("R9", 10, 0, 0, 8'h7D);
        step("R10", 8, 0, 0, 8'hE1);
        step("R10", 8, 0, 0, 8'hE2);
        step("R10", 8, 0, 0, 8'hE3);
        step("R10", 1, 7'h00, 0, 0);
        step("R10", 9, 0, 0, 0);
        step("R10", 9, 0, 0, 0);
        step("R10", 0, 0, 0, 0);
        step("R9", 10, 0, 0, 8'h30);
        step("R10", 8, 0, 0, 8'h01);

        // random stream over all commands
        for (int n = 0; n < 3000; n++) begin
            int c;
            c = $urandom_range(0, 15);
            step("R11", c, $urandom_range(0, 127), $urandom_range(0, 7), $urandom_range(0, 255));
        end

        // R1: reset again mid-run
        @(negedge clk);
        rst = 1'b1; cmd = 4'd0;
        @(negedge clk);
        rst = 1'b0;
        m_sp = 7; m_bank = 0; m_rdata = '0; m_rbit = 1'b0; m_ovf = 1'b0;
        #1;
        compare_all("R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule